// File: doc/BRIEF.md
# Shared MDIO Management Master with Per-Port Address Filter

This block lets several requesters share one Clause 22 MDIO management bus. Requester 0 is a global requester that may talk to any PHY address. Requesters 1 to NPORT are per-port requesters. Each one may reach only the single PHY address held in its own configuration word. A per-port request that names any other address never reaches the wire. It completes at once with an error flag, so the requester never hangs.

Accepted requests are granted in round-robin order, one whole frame per grant, and pass to a single serialiser. The serialiser derives MDC from the system clock and drives MDIO with an output enable. It releases the line to the PHY for the read turnaround and the read data. The configuration words are written during initialisation. After that the lock input freezes them until the next reset.

Top module: `mdio_share_top`

## Requirements
- R1: After reset, mdc and mdio_oe are low, mdio_o is high, no req_ready or rsp_done bit is set, and every port's PHY-address field reads 0.
- R2: Every granted, allowed request produces one 64-bit frame on mdio_o, MSB first. The frame is 32 ones, start bits 01, opcode 10 for a read or 01 for a write, a 5-bit PHY address, a 5-bit register address, a 2-bit turnaround (10 on writes) and 16 data bits.
- R3: mdc has a period of 2*MDC_HALF system clocks during a frame and stays low between frames. mdio_o changes only together with a falling mdc edge.
- R4: mdio_oe is high from the first preamble bit to the end of a write frame. In a read frame it is low from the first turnaround bit through the last data bit, and the PHY's bits sampled on rising mdc edges form rsp_rdata.
- R5: Requester 0 (req_write=1 means write) is never filtered. It gets a frame for any PHY address, and its rsp_done pulse comes with rsp_err=0 and the read data.
- R6: A per-port requester p whose req_phy equals its configured field gets a normal frame and completes with rsp_err=0.
- R7: A per-port request whose req_phy differs from its field causes no mdc activity. Its rsp_done pulse comes one clock after req_ready, with rsp_err=1 and rsp_rdata=16'hFFFF.
- R8: Port p (1..NPORT) has a 32-bit configuration word at byte address 0x40*(p-1). Its PHY-address field sits in bits 12:8, and all other bits read as 0. cfg_rdata returns the word at cfg_addr one clock later.
- R9: After a cycle with cfg_lock high, configuration writes are ignored until reset. Reset clears both the lock and the fields.
- R10: With several requests pending, grants follow round-robin order starting after the last granted requester. At most one req_ready bit is high at a time, and no new grant is given until the current request has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration byte address for read and write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_lock | input | 1 | Locks configuration until reset |
| cfg_rdata | output | 32 | Registered configuration read data |
| req_valid | input | NREQ | Request valid per requester (0 = global) |
| req_write | input | NREQ | 1 = write, 0 = read |
| req_phy | input | NREQ*5 | PHY address per requester |
| req_reg | input | NREQ*5 | Register address per requester |
| req_wdata | input | NREQ*16 | Write data per requester |
| req_ready | output | NREQ | One-cycle accept pulse |
| rsp_done | output | NREQ | One-cycle completion pulse |
| rsp_err | output | 1 | Set with rsp_done when the request was filtered |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench goes after the filter boundary. A port whose field is 0 is tested with address 0 (must pass) and address 3 (must drop). A filter that compared the wrong bits, or skipped the check, would put a frame on the wire, and the frame counter catches that. A locked write is followed by a readback and by a request to the new address. A lock that leaked would change the readback and let that request through. The read turnaround is checked bit by bit against mdio_oe, because a serialiser that released the line one bit late would fight the PHY. With all three requesters asserted together, the bench checks grant order and that each grant waits for the previous completion, which catches both a fixed-priority arbiter and a preempting one.

// File: rtl/mdio_share_pkg.sv
package mdio_share_pkg;
  localparam int PHY_W      = 5;
  localparam int REG_W      = 5;
  localparam int DATA_W     = 16;
  localparam int STRIDE_LSB = 6;   // 0x40 between port words
  localparam int FIELD_LSB  = 8;   // PHY field at bits 12:8

  typedef struct packed {
    logic              wr;
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  regad;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;

  typedef enum logic [1:0] {ARB_IDLE, ARB_WAIT, ARB_DROP} arb_st_t;
endpackage

// File: rtl/mdio_port_cfg.sv
module mdio_port_cfg
  import mdio_share_pkg::*;
#(
  parameter int NPORT  = 2,
  parameter int CFG_AW = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [CFG_AW-1:0]      addr,
  input  logic [31:0]            wdata,
  input  logic                   lock,
  output logic [31:0]            rdata,
  output logic [NPORT*PHY_W-1:0] phy_tab
);
  logic lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q  <= 1'b0;
      phy_tab <= '0;
      rdata   <= '0;
    end else begin
      if (lock) lock_q <= 1'b1;
      rdata <= '0;
      for (int p = 0; p < NPORT; p++) begin
        if (addr == CFG_AW'(p << STRIDE_LSB)) begin
          rdata[FIELD_LSB +: PHY_W] <= phy_tab[p*PHY_W +: PHY_W];
          if (we && !lock_q)
            phy_tab[p*PHY_W +: PHY_W] <= wdata[FIELD_LSB +: PHY_W];
        end
      end
    end
  end

  // R9: once locked, the field table is frozen
  a_r9_locked_frozen: assert property (@(posedge clk) disable iff (rst)
    (lock_q && $past(lock_q)) |-> $stable(phy_tab));
endmodule

// File: rtl/mdio_req_arb.sv
module mdio_req_arb
  import mdio_share_pkg::*;
#(
  parameter int NPORT = 2,
  localparam int NREQ = NPORT + 1,
  localparam int GW   = $clog2(NREQ)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NREQ-1:0]        valid,
  input  mdio_req_t [NREQ-1:0]   reqs,
  input  logic [NPORT*PHY_W-1:0] phy_tab,
  output logic [NREQ-1:0]        ready,
  output logic [NREQ-1:0]        done,
  output logic                   err,
  output logic [DATA_W-1:0]      rdata,
  output logic                   ser_start,
  output mdio_req_t              ser_req,
  input  logic                   ser_busy,
  input  logic                   ser_done,
  input  logic [DATA_W-1:0]      ser_rdata
);
  arb_st_t        st_q;
  logic [GW-1:0]  last_q, cur_q, pick;
  logic           found;
  logic [NREQ-1:0] allow;

  assign allow[0] = 1'b1;
  for (genvar i = 1; i < NREQ; i++) begin : g_filter
    assign allow[i] = (reqs[i].phy == phy_tab[(i-1)*PHY_W +: PHY_W]);
  end

  always_comb begin
    found = 1'b0;
    pick  = last_q;
    for (int k = NREQ; k >= 1; k--) begin
      if (valid[(int'(last_q) + k) % NREQ]) begin
        found = 1'b1;
        pick  = GW'((int'(last_q) + k) % NREQ);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ARB_IDLE;
      last_q    <= GW'(NREQ - 1);
      cur_q     <= '0;
      ready     <= '0;
      done      <= '0;
      err       <= 1'b0;
      rdata     <= '0;
      ser_start <= 1'b0;
      ser_req   <= '0;
    end else begin
      ready     <= '0;
      done      <= '0;
      ser_start <= 1'b0;
      unique case (st_q)
        ARB_IDLE: if (found) begin
          ready   <= NREQ'(1) << pick;
          last_q  <= pick;
          cur_q   <= pick;
          ser_req <= reqs[pick];
          if (allow[pick]) begin
            ser_start <= 1'b1;
            st_q      <= ARB_WAIT;
          end else begin
            st_q      <= ARB_DROP;
          end
        end
        ARB_WAIT: if (ser_done) begin
          done  <= NREQ'(1) << cur_q;
          err   <= 1'b0;
          rdata <= ser_rdata;
          st_q  <= ARB_IDLE;
        end
        ARB_DROP: begin
          done  <= NREQ'(1) << cur_q;
          err   <= 1'b1;
          rdata <= 16'hFFFF;
          st_q  <= ARB_IDLE;
        end
        default: st_q <= ARB_IDLE;
      endcase
    end
  end

  a_r10_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ready));
  a_r10_no_preempt: assert property (@(posedge clk) disable iff (rst)
    (st_q != ARB_IDLE && $past(st_q) != ARB_IDLE) |-> (ready == '0));
  a_r7_drop_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    (st_q == ARB_DROP) |-> !ser_busy);
  a_r7_err_all_ones: assert property (@(posedge clk) disable iff (rst)
    ((|done) && err) |-> (rdata == 16'hFFFF));
  a_r5_global_unfiltered: assert property (@(posedge clk) disable iff (rst)
    (st_q == ARB_DROP) |-> (cur_q != '0));
endmodule

// File: rtl/mdio_c22_ser.sv
module mdio_c22_ser
  import mdio_share_pkg::*;
#(
  parameter int MDC_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mdio_req_t         req,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FRAME_LEN = 64;
  localparam int BIT_W     = $clog2(FRAME_LEN);
  localparam int TA_IDX    = 46;
  localparam int DATA_IDX  = 48;
  localparam int CNT_W     = $clog2(MDC_HALF + 1);

  logic [FRAME_LEN-1:0] frame_q;
  logic [BIT_W-1:0]     bit_q;
  logic [BIT_W:0]       nxt_bit;
  logic [CNT_W-1:0]     cnt_q;
  logic                 is_rd_q;
  logic [DATA_W-1:0]    rsh_q;

  assign nxt_bit = {1'b0, bit_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; rdata <= '0;
      mdc <= 1'b0; mdio_o <= 1'b1; mdio_oe <= 1'b0;
      frame_q <= '0; bit_q <= '0; cnt_q <= '0; is_rd_q <= 1'b0; rsh_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          frame_q <= {32'hFFFF_FFFF, 2'b01, (req.wr ? 2'b01 : 2'b10), req.phy,
                      req.regad, (req.wr ? 2'b10 : 2'b11),
                      (req.wr ? req.wdata : 16'h0000)};
          is_rd_q <= !req.wr;
          busy    <= 1'b1;
          bit_q   <= '0;
          cnt_q   <= '0;
          rsh_q   <= '0;
          mdc     <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b1;
        end
      end else if (cnt_q != CNT_W'(MDC_HALF - 1)) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        if (!mdc) begin
          mdc <= 1'b1;
          if (is_rd_q && bit_q >= BIT_W'(DATA_IDX))
            rsh_q <= {rsh_q[DATA_W-2:0], mdio_i};
        end else begin
          mdc <= 1'b0;
          if (bit_q == BIT_W'(FRAME_LEN - 1)) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rdata   <= rsh_q;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
          end else begin
            bit_q   <= nxt_bit[BIT_W-1:0];
            frame_q <= {frame_q[FRAME_LEN-2:0], 1'b0};
            mdio_o  <= frame_q[FRAME_LEN-2];
            mdio_oe <= !(is_rd_q && nxt_bit >= (BIT_W+1)'(TA_IDX));
          end
        end
      end
    end
  end

  a_r3_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> $fell(mdc));
  a_r3_idle_clock_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));
  a_r4_read_released: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd_q && bit_q >= BIT_W'(TA_IDX)) |-> !mdio_oe);
  a_r4_write_driven: assert property (@(posedge clk) disable iff (rst)
    (busy && !is_rd_q && !$rose(busy)) |-> mdio_oe);
endmodule

// File: rtl/mdio_share_top.sv
module mdio_share_top
  import mdio_share_pkg::*;
#(
  parameter int  NPORT    = 2,
  parameter int  MDC_HALF = 2,
  localparam int NREQ     = NPORT + 1,
  localparam int IDX_W    = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int CFG_AW   = STRIDE_LSB + IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [31:0]           cfg_wdata,
  input  logic                  cfg_lock,
  output logic [31:0]           cfg_rdata,
  input  logic [NREQ-1:0]       req_valid,
  input  logic [NREQ-1:0]       req_write,
  input  logic [NREQ*PHY_W-1:0] req_phy,
  input  logic [NREQ*REG_W-1:0] req_reg,
  input  logic [NREQ*DATA_W-1:0] req_wdata,
  output logic [NREQ-1:0]       req_ready,
  output logic [NREQ-1:0]       rsp_done,
  output logic                  rsp_err,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  mdc,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  input  logic                  mdio_i
);
  mdio_req_t [NREQ-1:0]   reqs;
  logic [NPORT*PHY_W-1:0] phy_tab;
  logic                   ser_start, ser_busy, ser_done;
  mdio_req_t              ser_req;
  logic [DATA_W-1:0]      ser_rdata;

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    assign reqs[i] = '{wr:    req_write[i],
                       phy:   req_phy[i*PHY_W +: PHY_W],
                       regad: req_reg[i*REG_W +: REG_W],
                       wdata: req_wdata[i*DATA_W +: DATA_W]};
  end

  mdio_port_cfg #(.NPORT(NPORT), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .lock(cfg_lock), .rdata(cfg_rdata), .phy_tab(phy_tab));

  mdio_req_arb #(.NPORT(NPORT)) u_arb (
    .clk(clk), .rst(rst), .valid(req_valid), .reqs(reqs), .phy_tab(phy_tab),
    .ready(req_ready), .done(rsp_done), .err(rsp_err), .rdata(rsp_rdata),
    .ser_start(ser_start), .ser_req(ser_req), .ser_busy(ser_busy),
    .ser_done(ser_done), .ser_rdata(ser_rdata));

  mdio_c22_ser #(.MDC_HALF(MDC_HALF)) u_ser (
    .clk(clk), .rst(rst), .start(ser_start), .req(ser_req), .busy(ser_busy),
    .done(ser_done), .rdata(ser_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));
endmodule

// File: tb/mdio_share_top_bench.sv
`timescale 1ns/1ps
module mdio_share_top_bench;
  localparam int  NPORT = 2;
  localparam int  NREQ  = NPORT + 1;
  localparam int  HALF  = 2;
  localparam int  AW    = 7;
  localparam time PER   = 2 * HALF * 20;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_lock = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [NREQ-1:0] req_valid = '0, req_write = '0, req_ready, rsp_done;
  logic [NREQ*5-1:0] req_phy = '0, req_reg = '0;
  logic [NREQ*16-1:0] req_wdata = '0;
  logic rsp_err, mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;
  logic [15:0] rsp_rdata;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mdio_share_top #(.NPORT(NPORT), .MDC_HALF(HALF)) u_mdio_share_top (
    .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_lock, .cfg_rdata,
    .req_valid, .req_write, .req_phy, .req_reg, .req_wdata, .req_ready,
    .rsp_done, .rsp_err, .rsp_rdata, .mdc, .mdio_o, .mdio_oe, .mdio_i);

  // PHY model on the wire
  logic [63:0] cap = '0, last_frame = '0;
  int idx = 0, frames = 0, oe_err = 0, per_err = 0;
  bit in_rd = 0;
  time last_rise = 0;
  logic [15:0] rsp_word;
  assign rsp_word = {3'b101, cap[27:23], cap[22:18], 3'b011};

  always @(posedge mdc) begin
    if (idx > 0 && ($time - last_rise) != PER) per_err++;
    last_rise = $time;
    if (idx == 35) in_rd = (cap[63-34] == 1'b1) && (mdio_o == 1'b0);
    if (mdio_oe !== !(in_rd && idx >= 46)) oe_err++;
    cap[63-idx] = mdio_o;
    idx++;
    if (idx == 64) begin
      last_frame = cap; frames++; idx = 0; in_rd = 0;
    end
  end

  always @(negedge mdc) begin
    if (in_rd && idx >= 48 && idx <= 63) mdio_i = rsp_word[63-idx];
    else mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkframe(input bit wr, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, (wr ? 2'b10 : 2'b11), (wr ? wd : 16'h0)};
  endfunction

  function automatic logic [15:0] phy_answer(input logic [4:0] phy, input logic [4:0] rg);
    return {3'b101, phy, rg, 3'b011};
  endfunction

  task automatic cfg_write(input int port, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = AW'((port - 1) * 64); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_read(input int port, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = AW'((port - 1) * 64);
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic do_req(input int r, input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd, output bit err, output logic [15:0] rd, output int lat);
    int w;
    @(negedge clk);
    req_valid[r] = 1; req_write[r] = wr; req_phy[r*5 +: 5] = phy;
    req_reg[r*5 +: 5] = rg; req_wdata[r*16 +: 16] = wd;
    w = 0;
    do begin @(negedge clk); w++; end while (!req_ready[r] && w < 5000);
    req_valid[r] = 0;
    lat = 0;
    while (!rsp_done[r] && lat < 5000) begin @(negedge clk); lat++; end
    err = rsp_err; rd = rsp_rdata;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    chk(mdc == 0 && mdio_oe == 0 && mdio_o == 1, "R1 wire idle after reset", {mdc, mdio_oe, mdio_o}, 3'b001);
    chk(req_ready == 0 && rsp_done == 0, "R1 no ready/done after reset", {req_ready, rsp_done}, 0);
    for (int p = 1; p <= NPORT; p++) begin
      cfg_read(p, d);
      chk(d == 0, "R1 field resets to 0", d, 0);
    end
  endtask

  task automatic t_cfg_map();
    logic [31:0] d;
    cfg_write(1, 32'h0000_0500);
    cfg_read(1, d);
    chk(d == 32'h0000_0500, "R8 port1 word at 0x00", d, 32'h0000_0500);
    cfg_write(2, 32'hFFFF_FFFF);
    cfg_read(2, d);
    chk(d == 32'h0000_1F00, "R8 only bits 12:8 kept at 0x40", d, 32'h0000_1F00);
    cfg_write(2, 32'h0);
    cfg_read(1, d);
    chk(d == 32'h0000_0500, "R8 port words independent", d, 32'h0000_0500);
  endtask

  task automatic t_global();
    bit e; logic [15:0] rd; int lat, f0;
    f0 = frames;
    do_req(0, 0, 5'd7, 5'd3, 16'h0, e, rd, lat);
    chk(frames == f0 + 1, "R5 global read reaches wire", frames, f0 + 1);
    chk(last_frame[63:18] == mkframe(0, 5'd7, 5'd3, 0) >> 18, "R2 read frame header", last_frame, mkframe(0, 5'd7, 5'd3, 0));
    chk(!e && rd == phy_answer(5'd7, 5'd3), "R4 read data sampled from PHY", {e, rd}, {1'b0, phy_answer(5'd7, 5'd3)});
    do_req(0, 1, 5'd31, 5'd17, 16'hA5C3, e, rd, lat);
    chk(frames == f0 + 2 && !e, "R5 global write to address 31", frames, f0 + 2);
    chk(last_frame == mkframe(1, 5'd31, 5'd17, 16'hA5C3), "R2 write frame bits", last_frame, mkframe(1, 5'd31, 5'd17, 16'hA5C3));
    chk(oe_err == 0, "R4 output enable per bit", oe_err, 0);
    chk(per_err == 0, "R3 mdc period", per_err, 0);
  endtask

  task automatic t_ports();
    bit e; logic [15:0] rd; int lat, f0;
    f0 = frames;
    do_req(1, 1, 5'd5, 5'd9, 16'h1234, e, rd, lat);
    chk(frames == f0 + 1 && !e, "R6 port1 matching write", frames, f0 + 1);
    chk(last_frame == mkframe(1, 5'd5, 5'd9, 16'h1234), "R6 port1 frame", last_frame, mkframe(1, 5'd5, 5'd9, 16'h1234));
    do_req(1, 0, 5'd6, 5'd2, 16'h0, e, rd, lat);
    chk(e && rd == 16'hFFFF, "R7 mismatch err and all ones", {e, rd}, {1'b1, 16'hFFFF});
    chk(lat == 1, "R7 done one clock after ready", lat, 1);
    do_req(2, 0, 5'd3, 5'd1, 16'h0, e, rd, lat);
    chk(e && frames == f0 + 1, "R7 port2 field 0 drops address 3", frames, f0 + 1);
    do_req(2, 0, 5'd0, 5'd4, 16'h0, e, rd, lat);
    chk(!e && frames == f0 + 2 && rd == phy_answer(5'd0, 5'd4), "R6 port2 field 0 passes address 0", {e, rd}, {1'b0, phy_answer(5'd0, 5'd4)});
  endtask

  task automatic t_lock();
    logic [31:0] d; bit e; logic [15:0] rd; int lat, f0;
    @(negedge clk); cfg_lock = 1; @(negedge clk); cfg_lock = 0;
    cfg_write(1, 32'h0000_0900);
    cfg_read(1, d);
    chk(d == 32'h0000_0500, "R9 locked write ignored", d, 32'h0000_0500);
    f0 = frames;
    do_req(1, 0, 5'd9, 5'd0, 16'h0, e, rd, lat);
    chk(e && frames == f0, "R9 new address still filtered", frames, f0);
    do_req(1, 0, 5'd5, 5'd0, 16'h0, e, rd, lat);
    chk(!e && frames == f0 + 1, "R9 old address still served", frames, f0 + 1);
  endtask

  task automatic t_round_robin();
    int order[3], gcyc[3], dcyc[3], ng, nd, cyc, f0;
    f0 = frames; ng = 0; nd = 0; cyc = 0;
    @(negedge clk);
    req_write = '0;
    req_phy = {5'd0, 5'd5, 5'd12};
    req_reg = {5'd1, 5'd2, 5'd3};
    req_valid = '1;
    while (nd < 3 && cyc < 5000) begin
      @(negedge clk); cyc++;
      for (int i = 0; i < 3; i++) begin
        if (req_valid[i] && req_ready[i]) begin
          order[ng] = i; gcyc[ng] = cyc; ng++; req_valid[i] = 0;
        end
        if (rsp_done[i]) begin dcyc[i] = cyc; nd++; end
      end
    end
    chk(nd == 3 && ng == 3 && frames == f0 + 3, "R10 all three served", frames, f0 + 3);
    chk(order[1] == (order[0] + 1) % 3, "R10 second grant in rotation", order[1], (order[0] + 1) % 3);
    chk(order[2] == (order[1] + 1) % 3, "R10 third grant in rotation", order[2], (order[1] + 1) % 3);
    chk(gcyc[1] > dcyc[order[0]] && gcyc[2] > dcyc[order[1]], "R10 no grant before completion", gcyc[1], dcyc[order[0]]);
  endtask

  task automatic t_reset_unlocks();
    logic [31:0] d;
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    cfg_read(1, d);
    chk(d == 0, "R9 reset clears field", d, 0);
    cfg_write(1, 32'h0000_0300);
    cfg_read(1, d);
    chk(d == 32'h0000_0300, "R9 reset clears lock", d, 32'h0000_0300);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset_state();
    t_cfg_map();
    t_global();
    t_ports();
    t_lock();
    t_round_robin();
    t_reset_unlocks();
    chk(oe_err == 0 && per_err == 0, "R3 R4 wire timing overall", {oe_err, per_err}, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule